// File: doc/BRIEF.md
# Byte-Wide SPI Master with Wishbone Register Port

This block lets a processor on a Wishbone bus run an SPI device through five word-addressed registers. Software sets up the serial clock rate, the clock idle level, the sampling edge and the bit order in a control register, drives the single active-low chip select through a mask register, and starts a frame by writing one byte. The block then shifts eight bits out on the serial data output while capturing eight bits from the serial data input. Both directions run at the same time.

When the frame ends, the received byte is held for software and an interrupt line stays high until that byte is read. A status register reports whether the shifter is idle or busy, whether a received byte is waiting, and two sticky error conditions. The first error is a byte written while a frame was still running. The second is a frame that completed before the previous received byte had been read.

Top module: `spi_wb_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 (received byte, read only), 0x04 (transmit byte, write only), 0x08 (status), 0x0C (control, bits [4:0]) and 0x10 (select mask, bit 0). Data and control read back in their low bits with all upper bits zero. The transmit register and unmapped offsets read as zero.
- R2: After reset, every stored register is zero. Status therefore reads 0x20 (idle), the serial clock sits low, the chip select is high and the interrupt is low.
- R3: A request (cyc and stb high, ack low) is acknowledged in the next cycle for exactly one cycle. Read data is valid while ack is high.
- R4: Writing the transmit register while idle starts one 8-bit full-duplex frame. Control bit 0 = 1 sends the most significant bit first; 0 sends the least significant bit first. The captured byte is assembled in the same order.
- R5: Control bit 2 is the serial clock idle level. Control bit 1 = 0 samples input on the leading edge of each clock pulse; 1 samples on the trailing edge. Output data changes on the opposite edge.
- R6: Control bits [4:3] = code k give a serial clock half period of k+1 bus clock cycles, which divides the bus clock by 2, 4, 6 or 8. A frame has 16 clock edges.
- R7: Status bit 4 is high while a frame runs, and status bit 5 is high while the shifter is idle.
- R8: A transmit write during a frame is discarded. It sets status bit 3 and the summary error bit 7.
- R9: A frame completing while status bit 6 is still set sets status bit 2 and bit 7. The new byte replaces the old one.
- R10: Reading the received byte clears status bit 6. Any write to the status register clears bits 2, 3 and 7.
- R11: The interrupt output equals status bit 6. It rises only in the cycle a frame ends.
- R12: The chip select output is the inverse of select mask bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Register strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Active-low chip select |
| irq_o | output | 1 | Received-byte interrupt |

## Verification
A register access takes effect at the clock edge where the request is first seen. Ack and read data are due one cycle later, so the bench samples them at the following falling edge.

A frame starts at the edge that accepts the transmit write. The first serial clock edge follows k+1 cycles later. Busy, the received byte, the interrupt and the overrun flag all update at the 16th edge, (k+1)·16 cycles after the write.

The bench waits for that point by polling status rather than counting cycles. A serial monitor times the spacing between clock edges and compares the sampled data-out bits against a queue of expected frames. The data input is looped back inverted, so each received byte must equal the complement of the byte sent.

// File: rtl/spi_wbm_pkg.sv
// Shared definitions for the SPI master: frame width, register word indices
// and the packed layout of the control register (bit positions are software
// visible and must not move).
package spi_wbm_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2;

    typedef enum logic [2:0] {
        IDX_RXD  = 3'd0,
        IDX_TXD  = 3'd1,
        IDX_STAT = 3'd2,
        IDX_CTRL = 3'd3,
        IDX_MASK = 3'd4
    } reg_idx_e;

    // Control layout, MSB to LSB: rate code [4:3], idle level [2],
    // late-sample select [1], msb-first [0].
    typedef struct packed {
        logic [DIV_W-1:0] rate;
        logic             cpol;
        logic             cpha;
        logic             msb_first;
    } spi_cfg_t;

    localparam int CFG_W = $bits(spi_cfg_t);
endpackage

// File: rtl/spi_wbm_tick.sv
// Half-period timer: while run is high, pulses tick once every rate+1 cycles.
// Assumes run rises in the same edge that begins a frame, so the first tick
// lands rate+1 cycles after the start.
module spi_wbm_tick #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] rate,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == rate);

    // Count cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_wbm_shift.sv
// Frame engine: shifts W bits out and in over 2*W serial clock edges.
// Assumes start is only honoured while idle; the configuration is latched
// at start and held for the whole frame.
module spi_wbm_shift
    import spi_wbm_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  spi_cfg_t     cfg,
    input  logic         tick,
    input  logic         miso,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         phase,
    output logic         mosi,
    output spi_cfg_t     cfg_lat
);
    localparam int EC_W = $clog2(2 * W);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * W - 1);

    logic [W-1:0]    sh_q;
    logic [W-1:0]    rxs_q;
    logic [W-1:0]    rx_next;
    logic [EC_W-1:0] edge_q;
    logic            sample_now;

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // Sampling edge: leading (phase low) unless late sampling is selected.
    assign sample_now = busy && tick && (phase == cfg_lat.cpha);
    assign done       = busy && tick && (edge_q == LAST_EDGE);

    // Next captured word, including the bit sampled at this edge.
    always_comb begin
        rx_next = sample_now ? {rxs_q[W-2:0], miso} : rxs_q;
        rx_byte = cfg_lat.msb_first ? rx_next : flip(rx_next);
    end

    // Frame state: load on start, then shift or sample on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            phase   <= 1'b0;
            edge_q  <= '0;
            sh_q    <= '0;
            rxs_q   <= '0;
            mosi    <= 1'b0;
            cfg_lat <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            phase   <= 1'b0;
            edge_q  <= '0;
            cfg_lat <= cfg;
            sh_q    <= cfg.msb_first ? tx_byte : flip(tx_byte);
            mosi    <= cfg.msb_first ? tx_byte[W-1] : tx_byte[0];
        end else if (busy && tick) begin
            phase  <= ~phase;
            edge_q <= edge_q + 1'b1;
            rxs_q  <= rx_next;
            if (!sample_now) begin
                if (cfg_lat.cpha) begin
                    mosi <= sh_q[W-1];
                end else begin
                    mosi <= sh_q[W-2];
                end
                sh_q <= {sh_q[W-2:0], 1'b0};
            end
            if (edge_q == LAST_EDGE) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_wbm_regs.sv
// Register file and bus slave: decodes word accesses, holds control, mask,
// received byte and sticky flags, and returns read data one cycle after a
// request together with a one-cycle ack. Assumes the bus keeps the request
// stable until ack.
module spi_wbm_regs
    import spi_wbm_pkg::*;
#(
    parameter int ADR_W = 5,
    parameter int WB_W  = 32,
    parameter int W     = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [ADR_W-1:0] adr,
    input  logic [WB_W-1:0]  wdat,
    output logic [WB_W-1:0]  rdat,
    output logic             ack,
    input  logic             busy,
    input  logic             done,
    input  logic [W-1:0]     rx_byte,
    output logic             start,
    output logic [W-1:0]     tx_byte,
    output spi_cfg_t         cfg,
    output logic             ss_en,
    output logic             rx_ready,
    output logic             tx_ovr,
    output logic             stat_wr
);
    localparam int IDX_W = ADR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             acc;
    logic             wr_tx;
    logic             rd_rx;
    logic             rx_ovr;
    logic [W-1:0]     rx_q;
    logic [7:0]       stat_val;
    logic [WB_W-1:0]  rd_mux;

    assign idx     = adr[ADR_W-1:2];
    assign acc     = cyc && stb && !ack;
    assign wr_tx   = acc && we && (idx == IDX_W'(IDX_TXD));
    assign rd_rx   = acc && !we && (idx == IDX_W'(IDX_RXD));
    assign stat_wr = acc && we && (idx == IDX_W'(IDX_STAT));
    assign start   = wr_tx && !busy;
    assign tx_byte = wdat[W-1:0];

    assign stat_val = {tx_ovr | rx_ovr, rx_ready, ~busy, busy,
                       tx_ovr, rx_ovr, 2'b00};

    // Read data selection by word index.
    always_comb begin
        rd_mux = '0;
        case (idx)
            IDX_W'(IDX_RXD):  rd_mux[W-1:0]     = rx_q;
            IDX_W'(IDX_STAT): rd_mux[7:0]       = stat_val;
            IDX_W'(IDX_CTRL): rd_mux[CFG_W-1:0] = cfg;
            IDX_W'(IDX_MASK): rd_mux[0]         = ss_en;
            default:          rd_mux            = '0;
        endcase
    end

    // Bus handshake: one-cycle ack and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack  <= 1'b0;
            rdat <= '0;
        end else begin
            ack  <= acc;
            rdat <= (acc && !we) ? rd_mux : '0;
        end
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '0;
            ss_en <= 1'b0;
        end else if (acc && we) begin
            if (idx == IDX_W'(IDX_CTRL)) cfg   <= spi_cfg_t'(wdat[CFG_W-1:0]);
            if (idx == IDX_W'(IDX_MASK)) ss_en <= wdat[0];
        end
    end

    // Received byte and ready flag: completion wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_ready <= 1'b0;
        end else if (done) begin
            rx_q     <= rx_byte;
            rx_ready <= 1'b1;
        end else if (rd_rx) begin
            rx_ready <= 1'b0;
        end
    end

    // Sticky error flags: setting wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovr <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            if (wr_tx && busy)                     tx_ovr <= 1'b1;
            else if (stat_wr)                      tx_ovr <= 1'b0;
            if (done && rx_ready && !rd_rx)        rx_ovr <= 1'b1;
            else if (stat_wr)                      rx_ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_wb_master.sv
// Top level: byte-wide SPI master behind a Wishbone register port.
// Assumes a single synchronous bus clock; the serial clock is derived from
// it and all outputs are registered or simple functions of registers.
module spi_wb_master
    import spi_wbm_pkg::*;
#(
    parameter int ADR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [ADR_W-1:0] wb_adr_i,
    input  logic [31:0]      wb_dat_i,
    output logic [31:0]      wb_dat_o,
    output logic             wb_ack_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i,
    output logic             ss_n_o,
    output logic             irq_o
);
    logic              busy;
    logic              done;
    logic              tick;
    logic              start;
    logic              phase;
    logic              ss_en;
    logic              rx_ready;
    logic              tx_ovr;
    logic              stat_wr;
    logic              cpol_live;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;
    spi_cfg_t          cfg;
    spi_cfg_t          cfg_lat;

    spi_wbm_regs #(.ADR_W(ADR_W), .WB_W(32), .W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (wb_cyc_i),
        .stb      (wb_stb_i),
        .we       (wb_we_i),
        .adr      (wb_adr_i),
        .wdat     (wb_dat_i),
        .rdat     (wb_dat_o),
        .ack      (wb_ack_o),
        .busy     (busy),
        .done     (done),
        .rx_byte  (rx_byte),
        .start    (start),
        .tx_byte  (tx_byte),
        .cfg      (cfg),
        .ss_en    (ss_en),
        .rx_ready (rx_ready),
        .tx_ovr   (tx_ovr),
        .stat_wr  (stat_wr)
    );

    spi_wbm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .rate  (cfg_lat.rate),
        .tick  (tick)
    );

    spi_wbm_shift #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (tx_byte),
        .cfg     (cfg),
        .tick    (tick),
        .miso    (miso_i),
        .busy    (busy),
        .done    (done),
        .rx_byte (rx_byte),
        .phase   (phase),
        .mosi    (mosi_o),
        .cfg_lat (cfg_lat)
    );

    assign cpol_live = cfg.cpol;
    assign sclk_o    = (busy ? cfg_lat.cpol : cfg.cpol) ^ phase;
    assign ss_n_o    = ~ss_en;
    assign irq_o     = rx_ready;
endmodule

// File: rtl/spi_wb_master_chk.sv
// Property checker for spi_wb_master, attached by bind below. Observes the
// bus handshake, serial clock idle level, interrupt timing and error flag
// stickiness.
module spi_wb_master_chk (
    input logic clk,
    input logic rst_n,
    input logic wb_cyc_i,
    input logic wb_stb_i,
    input logic wb_ack_o,
    input logic sclk_o,
    input logic busy,
    input logic irq_o,
    input logic tx_ovr,
    input logic stat_wr,
    input logic cpol_live
);
    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o);

    assert_ack_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_o == cpol_live));

    assert_irq_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $fell(busy));

    assert_txovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovr && !stat_wr) |=> tx_ovr);
endmodule

bind spi_wb_master spi_wb_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_cyc_i  (wb_cyc_i),
    .wb_stb_i  (wb_stb_i),
    .wb_ack_o  (wb_ack_o),
    .sclk_o    (sclk_o),
    .busy      (busy),
    .irq_o     (irq_o),
    .tx_ovr    (tx_ovr),
    .stat_wr   (stat_wr),
    .cpol_live (cpol_live)
);

// File: tb/tb_spi_wb_master.sv
module tb_spi_wb_master;
    localparam int CLK_PERIOD = 10;
    localparam int ADR_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [ADR_W-1:0] adr = '0;
    logic [31:0]      wdat = '0;
    logic [31:0]      rdat;
    logic             ack, sclk, mosi, miso, ss_n, irq;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] wire_bits;
        logic       cpol;
        logic       cpha;
        int         half;
    } frame_t;
    frame_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso = ~mosi;

    spi_wb_master #(.ADR_W(ADR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb),
        .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
        .wb_ack_o(ack), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
        .ss_n_o(ss_n), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // R3: ack must be low when the request is driven and high one cycle later.
    task automatic bus(input logic w, input logic [ADR_W-1:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
        check("R3 ack low at request", 32'(ack), 32'd0);
        @(negedge clk);
        check("R3 ack after one cycle", 32'(ack), 32'd1);
        q = rdat;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [ADR_W-1:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [ADR_W-1:0] a, output logic [31:0] q);
        bus(1'b0, a, 32'h0, q);
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // Driver: push expected serial frame, then write transmit register.
    task automatic send(input logic [7:0] b, input logic [4:0] ctrl);
        frame_t f;
        f.wire_bits = ctrl[0] ? b : rev8(b);
        f.cpol = ctrl[2];
        f.cpha = ctrl[1];
        f.half = int'(ctrl[4:3]) + 1;
        exp_q.push_back(f);
        wr(5'h04, {24'h0, b});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(5'h08, s);
            if (!s[4]) return;
        end
        check("R7 frame never ended", 32'd1, 32'd0);
    endtask

    // Monitor: rebuild each frame from the serial lines and check edge spacing.
    initial begin
        logic       prev = 1'b0;
        int         gap = 0;
        int         edges = 0;
        logic [7:0] cap = '0;
        forever begin
            @(negedge clk);
            gap++;
            if (sclk !== prev) begin
                if (exp_q.size() > 0) begin
                    if (edges > 0) check("R6 half period", 32'(gap), 32'(exp_q[0].half));
                    if ((prev == exp_q[0].cpol) ^ exp_q[0].cpha) cap = {cap[6:0], mosi};
                    edges++;
                    if (edges == 16) begin
                        check("R4 R5 serial bits", 32'(cap), 32'(exp_q[0].wire_bits));
                        void'(exp_q.pop_front());
                        edges = 0;
                    end
                end
                gap = 0;
                prev = sclk;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic [4:0]  cfgs [6];
        logic [7:0]  data [6];
        cfgs = '{5'b00_0_0_1, 5'b01_0_0_0, 5'b10_1_0_1, 5'b11_1_1_0, 5'b00_0_1_1, 5'b01_1_1_0};
        data = '{8'hA5, 8'h3C, 8'h81, 8'h5E, 8'hF0, 8'h17};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 sclk idle", 32'(sclk), 32'd0);
        check("R2 ss_n", 32'(ss_n), 32'd1);
        check("R2 irq", 32'(irq), 32'd0);
        rd(5'h08, q); check("R2 status", q, 32'h20);
        rd(5'h0C, q); check("R2 control", q, 32'h0);
        rd(5'h10, q); check("R2 mask", q, 32'h0);
        rd(5'h00, q); check("R2 rx", q, 32'h0);

        // R1 register map and R12 select
        wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, q); check("R1 control readback", q, 32'h1F);
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, q); check("R1 mask readback", q, 32'h1);
        check("R12 select asserted", 32'(ss_n), 32'd0);
        rd(5'h04, q); check("R1 tx reads zero", q, 32'h0);
        rd(5'h14, q); check("R1 unmapped zero", q, 32'h0);

        // R4 R5 R6 R7 R10 R11 frames across modes
        for (int i = 0; i < 6; i++) begin
            wr(5'h0C, {27'h0, cfgs[i]});
            check("R5 idle level", 32'(sclk), 32'(cfgs[i][2]));
            send(data[i], cfgs[i]);
            rd(5'h08, q); check("R7 busy status", q, 32'h10);
            wait_idle();
            check("R11 irq high", 32'(irq), 32'd1);
            rd(5'h08, q); check("R7 R11 idle with data", q, 32'h60);
            rd(5'h00, q); check("R4 rx byte", q, {24'h0, ~data[i]});
            rd(5'h08, q); check("R10 ready cleared", q, 32'h20);
            check("R11 irq low", 32'(irq), 32'd0);
        end

        // R8 transmit overrun
        wr(5'h0C, 32'h19);
        send(8'hC3, 5'h19);
        wr(5'h04, 32'h77);
        rd(5'h08, q); check("R8 overrun flags", q, 32'h98);
        wait_idle();
        rd(5'h00, q); check("R8 discarded byte", q, 32'h3C);
        check("R8 no extra frame", 32'(exp_q.size()), 32'd0);
        rd(5'h08, q); check("R8 flags sticky", q, 32'hA8);
        wr(5'h08, 32'h0);
        rd(5'h08, q); check("R10 flags cleared", q, 32'h20);

        // R9 receive overrun
        wr(5'h0C, 32'h01);
        send(8'h12, 5'h01); wait_idle();
        send(8'h34, 5'h01); wait_idle();
        rd(5'h08, q); check("R9 overrun flags", q, 32'hE4);
        rd(5'h00, q); check("R9 newest byte", q, 32'hCB);
        wr(5'h08, 32'h0);
        rd(5'h08, q); check("R9 R10 cleared", q, 32'h20);

        // R12 deselect
        wr(5'h10, 32'h0);
        check("R12 select released", 32'(ss_n), 32'd1);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule